// File: doc/BRIEF.md
# Parallel Display Command Bus Bridge

This block connects a 32-bit memory-mapped register bus to a 16-bit parallel bus that drives up to two external display controller chips, each with its own chip-select line. Software writes a register to send a command word, a parameter word or a pair of pixel halfwords. It can also trigger a single read from a chip into a receive buffer. A data-select line tells the chips whether a bus cycle carries a command (low) or data (high).

A frame transfer is armed by loading a pixel count and writing a start bit. Each pixel-moving access counts the transfer down. When the count reaches zero the busy flag clears and a one-cycle frame-done pulse goes to the display controller's interrupt logic. The per-chip configuration and bus-timing words are held for software and are not used to shape the bus waveforms. The same applies to the bypass bit.

Top module: `panelbus_bridge`

## Requirements
- R1: After reset, all bus strobes, chip selects and `frameDone` are low. The status word at offset 0x04 reads 0x00000001, control (0x08) reads 0, pixel count (0x0C) reads 0, and each per-chip config word (0x30 and 0x40) reads 0x00310000.
- R2: A register write to offset 0x14 produces one write cycle on the next clock. In that cycle `pbData` carries the written bits 15:0, `pbDataSel` is low, and `pbCs` equals control bits {3,2}. When both of those bits are zero, no strobe and no chip select appear.
- R3: A register write to offset 0x18 produces the same single write cycle with `pbDataSel` high.
- R4: A register write to offset 0x1C produces two consecutive write cycles with `pbDataSel` high. The first carries bits 15:0 and the second bits 31:16. `regReady` stays low for exactly one cycle of the access.
- R5: The control register (0x08) keeps only bits 3:0: bit 0 enable, bit 1 bypass (stored only), bit 2 chip-select 0 enable, bit 3 chip-select 1 enable. Writing bit 4 set starts a frame only if all of these hold: the written bit 0 is 1, the block is not busy, and bits 3:2 of both config words are zero. Otherwise the start is ignored.
- R6: Each write to offset 0x1C, 0x20 or 0x24 decrements a nonzero pixel count, and the count does not go below zero. When a busy transfer reaches zero, busy clears and `frameDone` is high for exactly one cycle. A start with a count of zero gives the pulse at once and leaves busy low.
- R7: A write to 0x20 issues one read cycle with `pbDataSel` high. A write to 0x24 issues one with `pbDataSel` low. The read cycle selects chip 0 if it is enabled, otherwise chip 1. `pbRdData` is captured during the strobe cycle, and a read of 0x20 or 0x24 returns the captured value zero-extended.
- R8: The status word at 0x04 reads bit 0 as 1 and bit 8 as busy.
- R9: Writing 0x08 bits 3:0 and reading it back returns them. Bits above 3 read as zero.
- R10: A write to 0x00 with bit 1 set clears control, pixel count, line skip, the sync widths and busy, and reloads both config words with 0x00310000. Bits {4,3,0} of that write are kept and read back at 0x00.
- R11: Line skip (0x10) keeps 11 bits. Vertical (0x28) and horizontal (0x2C) sync widths keep 16 bits. Config words keep the mask 0x003F1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid while the access is selected |
| regReady | output | 1 | Access completes on the edge where this is high |
| pbData | output | 16 | Parallel bus word |
| pbDataSel | output | 1 | 0 = command cycle, 1 = data cycle |
| pbCs | output | 2 | Chip selects, active high |
| pbWrStb | output | 1 | One-clock write strobe |
| pbRdStb | output | 1 | One-clock read strobe |
| pbRdData | input | 16 | Word returned by the selected chip |
| frameDone | output | 1 | One-cycle frame completion pulse |

## Verification
Several properties are checked on every cycle:
- Strobe and chip-select consistency.
- A read cycle drives exactly one chip select.
- The data-select level that follows a command or parameter write.
- The one-cycle wait of a data write.
- The single-cycle width of the frame-done pulse.
- That busy only drops with a frame-done pulse or a soft reset.
- That the status bits reflect busy.

The rest comes only from the bench's scenarios. This covers the halfword order and the chip-select fan-out under random masks and words. It also covers the start-gating combinations, the countdown to zero and its saturation, the read-buffer capture and chip priority, and the soft-reset reload and field masking.

// File: rtl/panelbus_pkg.sv
package panelbus_pkg;
  // Register bus shape; the write word is split into two bus halfwords.
  localparam int REG_AW    = 8;
  localparam int REG_DW    = 32;
  localparam int BUS_W     = REG_DW / 2;
  localparam int NUM_CHIPS = 2;
  localparam int CNT_W     = 32;
  localparam int LINE_W    = 11;
  localparam int SYNC_W    = 16;
  localparam int CTRL_W    = 4;

  localparam logic [REG_AW-1:0] A_SYSCFG  = 8'h00;
  localparam logic [REG_AW-1:0] A_SYSSTAT = 8'h04;
  localparam logic [REG_AW-1:0] A_CTRL    = 8'h08;
  localparam logic [REG_AW-1:0] A_PIXCNT  = 8'h0C;
  localparam logic [REG_AW-1:0] A_LINESK  = 8'h10;
  localparam logic [REG_AW-1:0] A_CMD     = 8'h14;
  localparam logic [REG_AW-1:0] A_PARAM   = 8'h18;
  localparam logic [REG_AW-1:0] A_DATA    = 8'h1C;
  localparam logic [REG_AW-1:0] A_RDDATA  = 8'h20;
  localparam logic [REG_AW-1:0] A_RDSTAT  = 8'h24;
  localparam logic [REG_AW-1:0] A_VSW     = 8'h28;
  localparam logic [REG_AW-1:0] A_HSW     = 8'h2C;
  localparam int                CHIP_BASE   = 'h30;
  localparam int                CHIP_STRIDE = 'h10;
  localparam int                OFF_CFG  = 0;
  localparam int                OFF_TIME = 4;
  localparam int                OFF_CYC  = 8;

  localparam logic [REG_DW-1:0] CFG_RST   = 32'h0031_0000;
  localparam logic [REG_DW-1:0] CFG_MASK  = 32'h003F_1FFF;
  localparam logic [REG_DW-1:0] TIME_MASK = 32'h3FFF_FFFF;
  localparam logic [REG_DW-1:0] CYC_MASK  = 32'h0FFF_FFFF;
  localparam logic [REG_DW-1:0] IDLE_MASK = 32'h0000_0019;

  localparam int CTL_ENABLE = 0;
  localparam int CTL_CS_LO  = 2;
  localparam int CTL_START  = 4;
  localparam int SYS_SRST   = 1;

  typedef struct packed {
    logic regWr;   // accepted register write
    logic pixDec;  // pixel-moving access accepted
    logic capRx;   // read strobe active: capture returned word
  } pbStrobes_t;
endpackage

// File: rtl/panelbus_ctrl.sv
module panelbus_ctrl
  import panelbus_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regSel,
  input  logic                 regWrite,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [REG_DW-1:0]    regWdata,
  output logic                 regReady,
  input  logic [NUM_CHIPS-1:0] csEnable,
  output pbStrobes_t           strb,
  output logic [BUS_W-1:0]     pbData,
  output logic                 pbDataSel,
  output logic [NUM_CHIPS-1:0] pbCs,
  output logic                 pbWrStb,
  output logic                 pbRdStb
);
  typedef enum logic {ST_IDLE, ST_HIGH} phase_t;
  phase_t state, nxtState;

  logic isData, firstHalf, accept, wrAcc, anyCs;
  logic nxtWr, nxtRd, nxtDs;
  logic [BUS_W-1:0] nxtData;
  logic [NUM_CHIPS-1:0] rdPick;

  assign isData    = regSel && regWrite && (regAddr == A_DATA);
  assign firstHalf = isData && (state == ST_IDLE);
  assign regReady  = !firstHalf;
  assign accept    = regSel && regReady;
  assign wrAcc     = accept && regWrite;
  assign anyCs     = |csEnable;
  // lowest enabled chip select wins a read cycle
  assign rdPick    = csEnable & (~csEnable + NUM_CHIPS'(1));

  always_comb begin
    nxtWr    = 1'b0;
    nxtRd    = 1'b0;
    nxtDs    = pbDataSel;
    nxtData  = pbData;
    nxtState = state;
    if (firstHalf) begin
      nxtWr    = 1'b1;
      nxtDs    = 1'b1;
      nxtData  = regWdata[BUS_W-1:0];
      nxtState = ST_HIGH;
    end else begin
      if (state == ST_HIGH && !isData) nxtState = ST_IDLE;
      if (wrAcc) begin
        case (regAddr)
          A_CMD:    begin nxtWr = 1'b1; nxtDs = 1'b0; nxtData = regWdata[BUS_W-1:0]; end
          A_PARAM:  begin nxtWr = 1'b1; nxtDs = 1'b1; nxtData = regWdata[BUS_W-1:0]; end
          A_DATA:   begin
            nxtWr    = 1'b1;
            nxtDs    = 1'b1;
            nxtData  = regWdata[REG_DW-1:BUS_W];
            nxtState = ST_IDLE;
          end
          A_RDDATA: begin nxtRd = 1'b1; nxtDs = 1'b1; end
          A_RDSTAT: begin nxtRd = 1'b1; nxtDs = 1'b0; end
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pbWrStb   <= 1'b0;
      pbRdStb   <= 1'b0;
      pbCs      <= '0;
      pbDataSel <= 1'b0;
      pbData    <= '0;
    end else begin
      state     <= nxtState;
      pbWrStb   <= nxtWr && anyCs;
      pbRdStb   <= nxtRd && anyCs;
      pbCs      <= nxtWr ? csEnable : (nxtRd ? rdPick : '0);
      pbDataSel <= nxtDs;
      pbData    <= nxtData;
    end
  end

  assign strb.regWr  = wrAcc;
  assign strb.pixDec = wrAcc && ((regAddr == A_DATA) || (regAddr == A_RDDATA) ||
                                 (regAddr == A_RDSTAT));
  assign strb.capRx  = pbRdStb;
endmodule

// File: rtl/panelbus_regs.sv
module panelbus_regs
  import panelbus_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pbStrobes_t           strb,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [REG_DW-1:0]    regWdata,
  input  logic [BUS_W-1:0]     pbRdData,
  output logic [REG_DW-1:0]    regRdata,
  output logic [NUM_CHIPS-1:0] csEnable,
  output logic                 busy,
  output logic                 frameDone
);
  logic [REG_DW-1:0] idleBits;
  logic [CTRL_W-1:0] ctrlBits;
  logic [CNT_W-1:0]  pixCnt;
  logic [LINE_W-1:0] lineSkip;
  logic [SYNC_W-1:0] vsyncW, hsyncW;
  logic [BUS_W-1:0]  rxBuf;
  logic [REG_DW-1:0] chipCfg  [NUM_CHIPS];
  logic [REG_DW-1:0] chipTime [NUM_CHIPS];
  logic [REG_DW-1:0] chipCyc  [NUM_CHIPS];
  logic [NUM_CHIPS-1:0] gateBits;
  logic softRst, startOk;

  assign softRst = strb.regWr && (regAddr == A_SYSCFG) && regWdata[SYS_SRST];
  assign startOk = regWdata[CTL_START] && regWdata[CTL_ENABLE] && !busy && !(|gateBits);
  assign csEnable = ctrlBits[CTL_CS_LO +: NUM_CHIPS];

  // per-chip configuration and stored-only timing words
  for (genvar gi = 0; gi < NUM_CHIPS; gi++) begin : g_chip
    localparam logic [REG_AW-1:0] BASE = REG_AW'(CHIP_BASE + gi * CHIP_STRIDE);
    logic [REG_DW-1:0] cfgQ, timeQ, cycQ;
    always_ff @(posedge clk) begin
      if (!rstN || softRst) begin
        cfgQ  <= CFG_RST;
        timeQ <= '0;
        cycQ  <= '0;
      end else if (strb.regWr) begin
        if (regAddr == BASE + REG_AW'(OFF_CFG))  cfgQ  <= regWdata & CFG_MASK;
        if (regAddr == BASE + REG_AW'(OFF_TIME)) timeQ <= regWdata & TIME_MASK;
        if (regAddr == BASE + REG_AW'(OFF_CYC))  cycQ  <= regWdata & CYC_MASK;
      end
    end
    assign chipCfg[gi]  = cfgQ;
    assign chipTime[gi] = timeQ;
    assign chipCyc[gi]  = cycQ;
    assign gateBits[gi] = |cfgQ[3:2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleBits  <= '0;
      ctrlBits  <= '0;
      pixCnt    <= '0;
      lineSkip  <= '0;
      vsyncW    <= '0;
      hsyncW    <= '0;
      rxBuf     <= '0;
      busy      <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (softRst) begin
        idleBits <= regWdata & IDLE_MASK;
        ctrlBits <= '0;
        pixCnt   <= '0;
        lineSkip <= '0;
        vsyncW   <= '0;
        hsyncW   <= '0;
        rxBuf    <= '0;
        busy     <= 1'b0;
      end else begin
        if (strb.capRx) rxBuf <= pbRdData;
        if (strb.regWr) begin
          case (regAddr)
            A_SYSCFG: idleBits <= regWdata & IDLE_MASK;
            A_CTRL: begin
              ctrlBits <= regWdata[CTRL_W-1:0];
              if (startOk) begin
                if (pixCnt == '0) frameDone <= 1'b1;
                else              busy      <= 1'b1;
              end
            end
            A_PIXCNT: pixCnt   <= CNT_W'(regWdata);
            A_LINESK: lineSkip <= regWdata[LINE_W-1:0];
            A_VSW:    vsyncW   <= regWdata[SYNC_W-1:0];
            A_HSW:    hsyncW   <= regWdata[SYNC_W-1:0];
            default:  ;
          endcase
        end
        if (strb.pixDec && pixCnt != '0) begin
          pixCnt <= pixCnt - CNT_W'(1);
          if (pixCnt == CNT_W'(1) && busy) begin
            busy      <= 1'b0;
            frameDone <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_SYSCFG:  regRdata = idleBits;
      A_SYSSTAT: regRdata = {{(REG_DW-9){1'b0}}, busy, 7'b0, 1'b1};
      A_CTRL:    regRdata = REG_DW'(ctrlBits);
      A_PIXCNT:  regRdata = REG_DW'(pixCnt);
      A_LINESK:  regRdata = REG_DW'(lineSkip);
      A_RDDATA,
      A_RDSTAT:  regRdata = REG_DW'(rxBuf);
      A_VSW:     regRdata = REG_DW'(vsyncW);
      A_HSW:     regRdata = REG_DW'(hsyncW);
      default:   ;
    endcase
    for (int i = 0; i < NUM_CHIPS; i++) begin
      if (regAddr == REG_AW'(CHIP_BASE + i * CHIP_STRIDE + OFF_CFG))  regRdata = chipCfg[i];
      if (regAddr == REG_AW'(CHIP_BASE + i * CHIP_STRIDE + OFF_TIME)) regRdata = chipTime[i];
      if (regAddr == REG_AW'(CHIP_BASE + i * CHIP_STRIDE + OFF_CYC))  regRdata = chipCyc[i];
    end
  end
endmodule

// File: rtl/panelbus_bridge.sv
module panelbus_bridge
  import panelbus_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regSel,
  input  logic                 regWrite,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [REG_DW-1:0]    regWdata,
  output logic [REG_DW-1:0]    regRdata,
  output logic                 regReady,
  output logic [BUS_W-1:0]     pbData,
  output logic                 pbDataSel,
  output logic [NUM_CHIPS-1:0] pbCs,
  output logic                 pbWrStb,
  output logic                 pbRdStb,
  input  logic [BUS_W-1:0]     pbRdData,
  output logic                 frameDone
);
  pbStrobes_t           strb;
  logic [NUM_CHIPS-1:0] csEnable;
  logic                 busy;

  panelbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regReady(regReady),
    .csEnable(csEnable), .strb(strb), .pbData(pbData), .pbDataSel(pbDataSel),
    .pbCs(pbCs), .pbWrStb(pbWrStb), .pbRdStb(pbRdStb)
  );

  panelbus_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr), .regWdata(regWdata),
    .pbRdData(pbRdData), .regRdata(regRdata), .csEnable(csEnable),
    .busy(busy), .frameDone(frameDone)
  );
endmodule

// File: rtl/panelbus_checker.sv
module panelbus_checker
  import panelbus_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regSel,
  input logic                 regWrite,
  input logic [REG_AW-1:0]    regAddr,
  input logic                 wdataSrst,
  input logic                 statBusyBit,
  input logic                 statDoneBit,
  input logic                 regReady,
  input logic                 pbDataSel,
  input logic [NUM_CHIPS-1:0] pbCs,
  input logic                 pbWrStb,
  input logic                 pbRdStb,
  input logic                 frameDone,
  input logic                 busy
);
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    (pbWrStb || pbRdStb) |-> (pbCs != '0)); // R2
  AST_CS_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (pbCs != '0) |-> (pbWrStb || pbRdStb)); // R2
  AST_CMD_SEL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWrite && regAddr == A_CMD && regReady) |=> !pbDataSel); // R2
  AST_PARAM_SEL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWrite && regAddr == A_PARAM && regReady) |=> pbDataSel); // R3
  AST_DATA_ONE_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWrite && regAddr == A_DATA && !regReady) |=> regReady); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R6
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (frameDone ||
      $past(regSel && regWrite && regAddr == A_SYSCFG && wdataSrst))); // R6
  AST_RD_SINGLE_CS: assert property (@(posedge clk) disable iff (!rstN)
    pbRdStb |-> ($countones(pbCs) == 1 && !pbWrStb)); // R7
  AST_STATUS_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && !regWrite && regAddr == A_SYSSTAT) |-> (statDoneBit && statBusyBit == busy)); // R8
endmodule

bind panelbus_bridge panelbus_checker u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite), .regAddr(regAddr),
  .wdataSrst(regWdata[1]), .statBusyBit(regRdata[8]), .statDoneBit(regRdata[0]),
  .regReady(regReady), .pbDataSel(pbDataSel), .pbCs(pbCs), .pbWrStb(pbWrStb),
  .pbRdStb(pbRdStb), .frameDone(frameDone), .busy(busy)
);

// File: tb/panelbus_bridge_bench.sv
`timescale 1ns/1ps
module panelbus_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0, regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regReady;
  logic [15:0] pbData;
  logic        pbDataSel;
  logic [1:0]  pbCs;
  logic        pbWrStb, pbRdStb;
  logic [15:0] pbRdData = '0;
  logic        frameDone;

  int checks = 0, errors = 0, fdCnt = 0, evN = 0;
  logic [15:0] evData [512];
  logic        evDs   [512];
  logic [1:0]  evCs   [512];
  logic        evRd   [512];
  bit          finished = 0;

  always #5 clk = ~clk;

  panelbus_bridge u_panelbus_bridge (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .regReady(regReady), .pbData(pbData),
    .pbDataSel(pbDataSel), .pbCs(pbCs), .pbWrStb(pbWrStb), .pbRdStb(pbRdStb),
    .pbRdData(pbRdData), .frameDone(frameDone)
  );

  always @(negedge clk) begin
    if (rstN && (pbWrStb || pbRdStb) && evN < 512) begin
      evData[evN] = pbData; evDs[evN] = pbDataSel; evCs[evN] = pbCs; evRd[evN] = pbRdStb;
      evN++;
    end
    if (rstN && frameDone) fdCnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge with no access pending; returns at a negedge
  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rdv, output int waits);
    regSel = 1'b1; regWrite = wr; regAddr = a; regWdata = d; waits = 0;
    #1;
    while (!regReady) begin @(posedge clk); #1; waits++; end
    rdv = regRdata;
    @(posedge clk);
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] v; int w;
    access(1'b1, a, d, v, w);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    int w;
    access(1'b0, a, 32'h0, v, w);
  endtask

  function automatic logic expDs(input int op);
    return (op == 0) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic [15:0] expWord(input int op, input logic [31:0] d, input int half);
    return (op == 2 && half == 1) ? d[31:16] : d[15:0];
  endfunction

  initial begin
    logic [31:0] v;
    int w, base, fdBase, seedDummy;
    seedDummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 strobes", {29'b0, pbWrStb, pbRdStb, frameDone}, 32'h0);
    check("R1 cs", {30'b0, pbCs}, 32'h0);
    rd(8'h04, v); check("R1 status", v, 32'h1);
    rd(8'h08, v); check("R1 control", v, 32'h0);
    rd(8'h0C, v); check("R1 pixcnt", v, 32'h0);
    rd(8'h30, v); check("R1 cfg0", v, 32'h0031_0000);
    rd(8'h40, v); check("R1 cfg1", v, 32'h0031_0000);

    // R9 control keeps low 4 bits
    wr(8'h08, 32'hFFFF_FFEE); rd(8'h08, v); check("R9 control mask", v, 32'hE);

    // R2 command with no chip select enabled: no cycle
    wr(8'h08, 32'h0); base = evN;
    wr(8'h14, 32'h1234_5678); idle(2);
    check("R2 no cs no strobe", evN - base, 0);

    // R4 data write waits one cycle
    wr(8'h08, 32'h4); base = evN;
    access(1'b1, 8'h1C, 32'hCAFE_BEEF, v, w); idle(2);
    check("R4 ready wait", w, 1);
    check("R4 two cycles", evN - base, 2);
    check("R4 low half", evData[base], 32'hBEEF);
    check("R4 high half", evData[base+1], 32'hCAFE);

    // R2/R3/R4 random fan-out
    for (int it = 0; it < 48; it++) begin
      logic [1:0] mask; int op; logic [31:0] d; int nExp;
      mask = 2'($urandom_range(0, 3));
      op   = $urandom_range(0, 2);
      d    = $urandom;
      wr(8'h08, {28'b0, mask, 2'b00});
      base = evN;
      wr((op == 0) ? 8'h14 : (op == 1) ? 8'h18 : 8'h1C, d);
      idle(2);
      nExp = (mask == 2'b00) ? 0 : ((op == 2) ? 2 : 1);
      check(op == 0 ? "R2 count" : op == 1 ? "R3 count" : "R4 count", evN - base, nExp);
      for (int h = 0; h < nExp; h++) begin
        check(op == 0 ? "R2 cs" : op == 1 ? "R3 cs" : "R4 cs", {30'b0, evCs[base+h]}, {30'b0, mask});
        check(op == 0 ? "R2 dsel" : op == 1 ? "R3 dsel" : "R4 dsel", {31'b0, evDs[base+h]}, {31'b0, expDs(op)});
        check(op == 0 ? "R2 word" : op == 1 ? "R3 word" : "R4 word", {16'b0, evData[base+h]}, {16'b0, expWord(op, d, h)});
        check("R2 write strobe", {31'b0, evRd[base+h]}, 32'h0);
      end
    end

    // R7 read cycles, chip priority and buffer
    wr(8'h08, 32'h8); pbRdData = 16'h1234; base = evN;
    wr(8'h20, 32'h0); idle(2);
    check("R7 rd count", evN - base, 1);
    check("R7 rd cs1", {30'b0, evCs[base]}, 32'h2);
    check("R7 rd dsel high", {31'b0, evDs[base]}, 32'h1);
    check("R7 rd strobe", {31'b0, evRd[base]}, 32'h1);
    rd(8'h20, v); check("R7 buffer", v, 32'h1234);
    rd(8'h24, v); check("R7 buffer alias", v, 32'h1234);
    wr(8'h08, 32'hC); pbRdData = 16'hBEEF; base = evN;
    wr(8'h24, 32'h0); idle(2);
    check("R7 rd cs0 priority", {30'b0, evCs[base]}, 32'h1);
    check("R7 rd dsel low", {31'b0, evDs[base]}, 32'h0);
    rd(8'h24, v); check("R7 status buffer", v, 32'hBEEF);

    // R5/R6/R8 frame transfer countdown
    fdBase = fdCnt;
    wr(8'h0C, 32'd3); wr(8'h08, 32'h15);
    rd(8'h04, v); check("R8 busy", v, 32'h101);
    wr(8'h1C, 32'h0001_0002); wr(8'h20, 32'h0);
    rd(8'h0C, v); check("R6 count", v, 32'd1);
    rd(8'h04, v); check("R6 still busy", v, 32'h101);
    wr(8'h24, 32'h0); idle(2);
    rd(8'h04, v); check("R6 busy clear", v, 32'h1);
    check("R6 frame done once", fdCnt - fdBase, 1);
    wr(8'h1C, 32'h0); rd(8'h0C, v); check("R6 saturate", v, 32'd0);
    check("R6 no extra pulse", fdCnt - fdBase, 1);

    // R6 start with zero count
    fdBase = fdCnt;
    wr(8'h08, 32'h15); idle(2);
    check("R6 zero-count pulse", fdCnt - fdBase, 1);
    rd(8'h04, v); check("R6 zero-count not busy", v, 32'h1);

    // R5 ignored starts
    wr(8'h0C, 32'd2); wr(8'h08, 32'h14);
    rd(8'h04, v); check("R5 disabled start ignored", v, 32'h1);
    wr(8'h30, 32'h4); wr(8'h08, 32'h15);
    rd(8'h04, v); check("R5 cfg0 gate", v, 32'h1);
    wr(8'h30, 32'h0); wr(8'h48, 32'h0); wr(8'h40, 32'h8); wr(8'h08, 32'h15);
    rd(8'h04, v); check("R5 cfg1 gate", v, 32'h1);
    wr(8'h40, 32'h0); wr(8'h08, 32'h15);
    rd(8'h04, v); check("R5 start ok", v, 32'h101);
    fdBase = fdCnt;
    wr(8'h0C, 32'd0); wr(8'h08, 32'h15); idle(2);
    check("R5 busy start ignored", fdCnt - fdBase, 0);
    rd(8'h04, v); check("R5 still busy", v, 32'h101);

    // R11 field masks
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, v); check("R11 cfg mask", v, 32'h003F_1FFF);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); check("R11 line skip", v, 32'h7FF);
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, v); check("R11 vsync", v, 32'hFFFF);
    wr(8'h2C, 32'h1234_ABCD); rd(8'h2C, v); check("R11 hsync", v, 32'hABCD);

    // R10 soft reset
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R10 idle bits", v, 32'h19);
    rd(8'h30, v); check("R10 cfg0 reload", v, 32'h0031_0000);
    rd(8'h10, v); check("R10 line skip clear", v, 32'h0);
    rd(8'h08, v); check("R10 control clear", v, 32'h0);
    rd(8'h04, v); check("R10 busy clear", v, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule